// File: doc/BRIEF.md
# Serial Receive FIFO with Trigger Level and Idle Timeout

This block buffers received characters for a serial port. Each byte that arrives from the deserializer is stored in a small circular queue. Software drains the queue by popping from the receive-data register. A data-ready flag and a receive interrupt are raised when the fill level reaches a trigger level that software chooses.

When fewer bytes than the trigger level sit in the queue and the line goes quiet, an idle timer raises the flag after a fixed number of character-time units. This lets a short tail of data be collected without waiting for the trigger. The character-time unit comes in as a single-cycle tick from the baud logic. Register decoding and bit-level reception are done elsewhere.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the count is 0, the data-ready flag and the interrupt are 0, and the read data reads 0.
- R2: Read data always presents the oldest stored byte. A pop removes that byte and lowers the count by one, so bytes leave in arrival order.
- R3: A byte that arrives while 16 bytes are stored is dropped. The count stays at 16 and the stored bytes are unchanged.
- R4: While the receive-enable input is 0, arriving bytes are ignored.
- R5: A pop while the queue is empty changes no state, and the read data is 0 whenever the queue is empty.
- R6: A push and a pop in the same cycle leave the count unchanged.
- R7: The trigger select chooses the trigger level: code 0 gives 1, code 1 gives 4, code 2 gives 8, code 3 gives 14. A push that brings the count to the trigger level or above sets the data-ready flag in the next cycle.
- R8: A pop that leaves the count below the trigger level clears the flag. A pop that leaves it at or above the trigger keeps the flag set.
- R9: The interrupt is high exactly when the data-ready flag is set and the interrupt-enable input is 1.
- R10: A push that leaves the count below the trigger starts the idle timer, or restarts it if it is running. On the 15th character tick after the timer starts, the flag is set.
- R11: A push that reaches the trigger stops a running idle timer.
- R12: A flush empties the queue, clears the flag and stops the idle timer.
- R13: A pop that empties the queue stops the idle timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Received-byte strobe |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Pop strobe from a receive-data read |
| flush_i | input | 1 | Empties the queue |
| trig_sel_i | input | 2 | Trigger level select |
| rx_en_i | input | 1 | Receive enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| etu_tick_i | input | 1 | One pulse per character-time unit |
| pop_data_o | output | 8 | Oldest stored byte, or 0 when empty |
| count_o | output | 5 | Number of stored bytes, 0 to 16 |
| rdy_o | output | 1 | Data-ready flag |
| irq_o | output | 1 | Receive interrupt |

## Verification
The checker watches the following on every cycle:
- the count bound and the drop of a byte on a full queue;
- ignored bytes while receive is disabled;
- empty pops and the zero read data;
- push-with-pop count stability;
- flag set on reaching the trigger, flag clear when a pop falls below it;
- the effect of a flush.

Some behaviours depend on history that spans many cycles, so only the bench scenarios show them:
- arrival order of the data;
- the exact 15-tick idle window and its restart by a new byte;
- a timer stopped by reaching the trigger or by emptying the queue, which must not set the flag later.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned l0,
                                             input int unsigned l1,
                                             input int unsigned l2,
                                             input int unsigned l3);
    case (sel)
      2'd0:    return l0;
      2'd1:    return l1;
      2'd2:    return l2;
      default: return l3;
    endcase
  endfunction
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[head_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i) head_q <= wrap_inc(head_q);
      if (rd_i) tail_q <= wrap_inc(tail_q);
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = empty_o ? '0 : mem_q[tail_q];
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int TIMEOUT_ETU = 15,
  localparam int TW         = $clog2(TIMEOUT_ETU + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  input  logic tick_i,
  output logic expire_o
);
  logic          active_q;
  logic [TW-1:0] cnt_q;
  logic          last;

  assign last     = (cnt_q == TW'(TIMEOUT_ETU - 1));
  // a restart or stop in the same cycle overrides expiry
  assign expire_o = active_q & tick_i & last & ~arm_i & ~cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cancel_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end
endmodule

// File: rtl/rx_trig_ctrl.sv
module rx_trig_ctrl #(
  parameter int DEPTH   = 16,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_ok_i,
  input  logic          pop_ok_i,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          expire_i,
  output logic          arm_o,
  output logic          cancel_o,
  output logic          rdy_o
);
  import serial_rx_pkg::*;

  logic [CW-1:0] nxt_cnt, trig;
  logic          reach, below, rdy_q;

  assign trig    = CW'(trig_level(trig_sel_i, TRIG_L0, TRIG_L1, TRIG_L2, TRIG_L3));
  assign nxt_cnt = count_i + CW'(push_ok_i) - CW'(pop_ok_i);
  assign reach   = push_ok_i & (nxt_cnt >= trig);
  assign below   = nxt_cnt < trig;

  assign arm_o    = push_ok_i & ~reach;
  assign cancel_o = flush_i | reach | (pop_ok_i & ~push_ok_i & (nxt_cnt == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdy_q <= 1'b0;
    else if (flush_i)           rdy_q <= 1'b0;
    else if (reach)             rdy_q <= 1'b1;
    else if (pop_ok_i && below) rdy_q <= 1'b0;
    else if (expire_i)          rdy_q <= 1'b1;
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DW          = 8,
  parameter int DEPTH       = 16,
  parameter int TIMEOUT_ETU = 15,
  parameter int TRIG_L0     = 1,
  parameter int TRIG_L1     = 4,
  parameter int TRIG_L2     = 8,
  parameter int TRIG_L3     = 14,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          rx_en_i,
  input  logic          rx_ie_i,
  input  logic          etu_tick_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          rdy_o,
  output logic          irq_o
);
  logic          empty, full, push_ok, pop_ok, arm, cancel, expire, rdy;
  logic [CW-1:0] count;

  assign push_ok = push_i & rx_en_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty & ~flush_i;

  rx_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .wr_i    (push_ok),
    .wdata_i (push_data_i),
    .rd_i    (pop_ok),
    .rdata_o (pop_data_o),
    .count_o (count),
    .empty_o (empty),
    .full_o  (full)
  );

  rx_trig_ctrl #(
    .DEPTH(DEPTH), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
    .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .push_ok_i  (push_ok),
    .pop_ok_i   (pop_ok),
    .count_i    (count),
    .trig_sel_i (trig_sel_i),
    .expire_i   (expire),
    .arm_o      (arm),
    .cancel_o   (cancel),
    .rdy_o      (rdy)
  );

  rx_idle_timer #(.TIMEOUT_ETU(TIMEOUT_ETU)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .cancel_i (cancel),
    .tick_i   (etu_tick_i),
    .expire_o (expire)
  );

  assign count_o = count;
  assign rdy_o   = rdy;
  assign irq_o   = rdy & rx_ie_i;
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          flush_i,
  input logic [1:0]    trig_sel_i,
  input logic          rx_en_i,
  input logic [DW-1:0] pop_data_o,
  input logic [CW-1:0] count_o,
  input logic          rdy_o
);
  import serial_rx_pkg::*;

  logic [CW-1:0] trig;
  assign trig = CW'(trig_level(trig_sel_i, TRIG_L0, TRIG_L1, TRIG_L2, TRIG_L3));

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CW'(DEPTH) && push_i && !pop_i && !flush_i) |=> count_o == CW'(DEPTH));

  assert_rx_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !rx_en_i && !pop_i && !flush_i) |=> $stable(count_o));

  assert_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && pop_i && !push_i && !flush_i) |=> count_o == '0);

  assert_empty_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> pop_data_o == '0);

  assert_push_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && rx_en_i && pop_i && !flush_i && count_o != '0 && count_o != CW'(DEPTH))
    |=> $stable(count_o));

  assert_trig_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && rx_en_i && !pop_i && !flush_i && count_o < CW'(DEPTH) &&
     (count_o + CW'(1)) >= trig) |=> rdy_o);

  assert_trig_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && count_o != '0 && (count_o - CW'(1)) < trig)
    |=> !rdy_o);

  assert_flush_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0 && !rdy_o));
endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(
  .DW(DW), .DEPTH(DEPTH), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
  .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .flush_i    (flush_i),
  .trig_sel_i (trig_sel_i),
  .rx_en_i    (rx_en_i),
  .pop_data_o (pop_data_o),
  .count_o    (count_o),
  .rdy_o      (rdy_o)
);

// File: tb/serial_rx_fifo_test.sv
`timescale 1ns/1ps
module serial_rx_fifo_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, flush_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic [1:0] trig_sel_i = '0;
  logic       rx_en_i = 1'b1, rx_ie_i = 1'b1, etu_tick_i = 1'b0;
  logic [7:0] pop_data_o;
  logic [4:0] count_o;
  logic       rdy_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  serial_rx_fifo uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .flush_i(flush_i), .trig_sel_i(trig_sel_i), .rx_en_i(rx_en_i),
    .rx_ie_i(rx_ie_i), .etu_tick_i(etu_tick_i), .pop_data_o(pop_data_o),
    .count_o(count_o), .rdy_o(rdy_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: inputs applied at a falling edge, outputs settle by the next one
  task automatic cyc(input logic p, input logic [7:0] d, input logic r,
                     input logic f, input logic t);
    push_i = p; push_data_i = d; pop_i = r; flush_i = f; etu_tick_i = t;
    @(negedge clk_i);
    push_i = 0; pop_i = 0; flush_i = 0; etu_tick_i = 0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 1);
  endtask

  function automatic int trig_of(input int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk_i);
    chk("R1 count", count_o, 0);
    chk("R1 rdy", rdy_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 data", pop_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep every trigger level over a full fill and drain
    for (int s = 0; s < 4; s++) begin
      trig_sel_i = 2'(s);
      cyc(0, 0, 0, 1, 0);
      for (int i = 0; i < 16; i++) begin
        cyc(1, 8'(s * 40 + i + 1), 0, 0, 0);
        chk("R2 count fill", count_o, i + 1);
        chk("R7 rdy on fill", rdy_o, (i + 1 >= trig_of(s)) ? 1 : 0);
        chk("R9 irq", irq_o, (i + 1 >= trig_of(s)) ? 1 : 0);
      end
      cyc(1, 8'hEE, 0, 0, 0);
      chk("R3 count full", count_o, 16);
      for (int i = 0; i < 16; i++) begin
        chk("R2 order", pop_data_o, s * 40 + i + 1);
        cyc(0, 0, 1, 0, 0);
        chk("R2 count drain", count_o, 15 - i);
        chk("R8 rdy on drain", rdy_o, (15 - i >= trig_of(s)) ? 1 : 0);
      end
      cyc(0, 0, 1, 0, 0);
      chk("R5 empty pop count", count_o, 0);
      chk("R5 empty pop data", pop_data_o, 0);
    end

    // receive disabled
    rx_en_i = 0;
    cyc(1, 8'h55, 0, 0, 0);
    chk("R4 count", count_o, 0);
    chk("R4 data", pop_data_o, 0);
    rx_en_i = 1;

    // simultaneous push and pop
    trig_sel_i = 2'd3;
    cyc(1, 8'h11, 0, 0, 0);
    cyc(1, 8'h22, 0, 0, 0);
    cyc(1, 8'h33, 1, 0, 0);
    chk("R6 count", count_o, 2);
    chk("R6 head", pop_data_o, 8'h22);

    // interrupt gated by enable
    trig_sel_i = 2'd0;
    cyc(0, 0, 0, 1, 0);
    rx_ie_i = 0;
    cyc(1, 8'h44, 0, 0, 0);
    chk("R9 rdy", rdy_o, 1);
    chk("R9 irq masked", irq_o, 0);
    rx_ie_i = 1;
    @(negedge clk_i);
    chk("R9 irq unmasked", irq_o, 1);

    // idle timeout
    trig_sel_i = 2'd2;
    cyc(0, 0, 0, 1, 0);
    cyc(1, 8'h01, 0, 0, 0);
    ticks(14);
    chk("R10 before timeout", rdy_o, 0);
    ticks(1);
    chk("R10 at timeout", rdy_o, 1);
    chk("R10 irq", irq_o, 1);
    cyc(0, 0, 0, 1, 0);
    cyc(1, 8'h02, 0, 0, 0);
    ticks(10);
    cyc(1, 8'h03, 0, 0, 0);
    ticks(14);
    chk("R10 rearmed", rdy_o, 0);
    ticks(1);
    chk("R10 rearm timeout", rdy_o, 1);

    // reaching the trigger stops the timer
    trig_sel_i = 2'd1;
    cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc(1, 8'(i), 0, 0, 0);
    chk("R11 rdy at trig", rdy_o, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R11 rdy below", rdy_o, 0);
    ticks(20);
    chk("R11 no late timeout", rdy_o, 0);

    // flush
    trig_sel_i = 2'd2;
    cyc(0, 0, 0, 1, 0);
    cyc(1, 8'h09, 0, 0, 0);
    cyc(1, 8'h0A, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R12 count", count_o, 0);
    ticks(20);
    chk("R12 timer stopped", rdy_o, 0);
    trig_sel_i = 2'd0;
    cyc(1, 8'h0B, 0, 0, 0);
    chk("R12 rdy set", rdy_o, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R12 rdy cleared", rdy_o, 0);
    chk("R12 data", pop_data_o, 0);

    // emptying pop stops the timer
    trig_sel_i = 2'd2;
    cyc(1, 8'h0C, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R13 count", count_o, 0);
    ticks(20);
    chk("R13 timer stopped", rdy_o, 0);

    finish_run();
  end
endmodule